// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces 14-bit operand addresses for indirect memory accesses. It holds four pointer registers, four step registers and four span registers. On an access the requester names one pointer and one step register. The block presents the named pointer's current value as the address in that same cycle. At the next clock edge it advances the pointer by the signed step value (post-modify).

A pointer whose span register is zero steps linearly and wraps at the 14-bit boundary. A pointer with a nonzero span steps inside a circular window of that many words. The window's base is the value last written into the pointer, rounded down to a multiple of the smallest power of two that is not below the span. A mirror control bit presents the pointer with its bit order reversed, for FFT-style addressing. Mirroring affects only the address output; the stored pointer still steps normally.

All twelve registers are written and read through one simple port that selects a register kind and an index.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every pointer, step and span register reads as zero, and `addrValid` is low while `accEn` is low.
- R2: A write with `wrEn` high loads `wrData` at the clock edge into the register chosen by `wrSel` and by `wrKind`: 2'b00 selects a pointer, 2'b01 a step register, 2'b10 a span register. `rdData` shows the register chosen by `rdKind` and `rdSel`, using the same encoding, in the same cycle.
- R3: A write with `wrKind` = 2'b11 changes no register.
- R4: While `accEn` is high, `addrValid` is high and `addrOut` shows the current value of the pointer chosen by `accPtrSel`. The value shown is the one held before that cycle's update.
- R5: With a zero span, an access sets the pointer to (pointer + step) mod 2^14. The step is read as a signed 14-bit two's-complement number.
- R6: With a nonzero span L, let P be the smallest power of two with P >= L, and let base = (value last written to the pointer) with its low log2(P) bits cleared. An access computes pointer + step. If the result is below base, L is added to it. If the result is at or above base+L, L is subtracted from it. The caller keeps |step| <= L and keeps the pointer inside [base, base+L).
- R7: An access changes only the chosen pointer. The other pointers and all step and span registers keep their values.
- R8: When a pointer write and an access name the same pointer in the same cycle, the written value is stored and no post-modify happens. `addrOut` still shows the old value in that cycle. A write to a different pointer and an access both take effect.
- R9: With `bitRevEn` high, bit i of `addrOut` equals bit 13-i of the chosen pointer. The pointer update is the same as with `bitRevEn` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | Write target kind: 00 pointer, 01 step, 10 span, 11 none |
| wrSel | input | 2 | Write target index |
| wrData | input | 14 | Write data |
| rdKind | input | 2 | Read kind, same encoding as wrKind (11 reads zero) |
| rdSel | input | 2 | Read index |
| rdData | output | 14 | Read data |
| accEn | input | 1 | Access request |
| accPtrSel | input | 2 | Pointer used by the access |
| accModSel | input | 2 | Step register used by the access |
| bitRevEn | input | 1 | Present the address bit-reversed |
| addrOut | output | 14 | Address for the current access |
| addrValid | output | 1 | Address valid, follows accEn |

## Verification
The circular-window assertions rely on the caller's side of R6. Every circular access uses a step no larger in magnitude than the span, and the pointer starts inside its window. Checker properties flag any access that breaks either condition. The bench meets both conditions by design: it places each circular pointer at an offset below the span from a base aligned to 16 words, and it limits the steps to +1, -1, +min(3,L) and -min(2,L). The bench restores every span to zero before the linear and mirrored sweeps, so those sweeps run free of the window precondition.

// File: rtl/circ_dag_pkg.sv
package circ_dag_pkg;
  localparam int DagAddrW  = 14;
  localparam int DagNumReg = 4;
  localparam int DagSelW   = $clog2(DagNumReg);

  typedef enum logic [1:0] {
    KIND_INDEX  = 2'b00,
    KIND_MODIFY = 2'b01,
    KIND_LENGTH = 2'b10,
    KIND_NONE   = 2'b11
  } regKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [DagNumReg-1:0] idxLoad;
    logic [DagNumReg-1:0] modLoad;
    logic [DagNumReg-1:0] lenLoad;
    logic [DagNumReg-1:0] ptrStep;
    logic [DagSelW-1:0]   ptrPick;
    logic [DagSelW-1:0]   modPick;
  } dagStrobe_t;
endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import circ_dag_pkg::*;
#(
  parameter int NUM_REG = DagNumReg,
  parameter int SEL_W   = DagSelW
) (
  input  logic             wrEn,
  input  logic [1:0]       wrKind,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             accEn,
  input  logic [SEL_W-1:0] accPtrSel,
  input  logic [SEL_W-1:0] accModSel,
  output dagStrobe_t       strb
);
  for (genvar gi = 0; gi < NUM_REG; gi++) begin : g_dec
    logic hitWr;
    assign hitWr = wrEn && (wrSel == SEL_W'(gi));
    assign strb.idxLoad[gi] = hitWr && (wrKind == KIND_INDEX);
    assign strb.modLoad[gi] = hitWr && (wrKind == KIND_MODIFY);
    assign strb.lenLoad[gi] = hitWr && (wrKind == KIND_LENGTH);
    // a pointer write in the same cycle suppresses the step
    assign strb.ptrStep[gi] = accEn && (accPtrSel == SEL_W'(gi)) && !strb.idxLoad[gi];
  end

  assign strb.ptrPick = accPtrSel;
  assign strb.modPick = accModSel;
endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import circ_dag_pkg::*;
#(
  parameter int ADDR_W  = DagAddrW,
  parameter int NUM_REG = DagNumReg,
  parameter int SEL_W   = DagSelW
) (
  input  logic              clk,
  input  logic              rstN,
  input  dagStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdKind,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic              bitRevEn,
  output logic [ADDR_W-1:0] rdData,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int EXT_W = ADDR_W + 2;

  logic [ADDR_W-1:0] idxReg    [NUM_REG];
  logic [ADDR_W-1:0] modReg    [NUM_REG];
  logic [ADDR_W-1:0] lenReg    [NUM_REG];
  logic [ADDR_W-1:0] anchorReg [NUM_REG];

  // all-ones mask of width ceil(log2(len))
  function automatic logic [ADDR_W-1:0] spanMask(input logic [ADDR_W-1:0] len);
    logic [ADDR_W-1:0] m;
    m = len - 1'b1;
    for (int s = 1; s < ADDR_W; s = s * 2) m = m | (m >> s);
    return m;
  endfunction

  logic [ADDR_W-1:0]       selPtr, selMod, selLen, selAnchor, selMask, stepNext;
  logic signed [EXT_W-1:0] stepSum, winLo, winHi, fixSum;

  // single shared stepper: only one pointer moves per cycle
  always_comb begin
    selPtr    = idxReg[strb.ptrPick];
    selMod    = modReg[strb.modPick];
    selLen    = lenReg[strb.ptrPick];
    selAnchor = anchorReg[strb.ptrPick];
    selMask   = spanMask(selLen);
    stepSum   = $signed({2'b00, selPtr}) + $signed({{2{selMod[ADDR_W-1]}}, selMod});
    winLo     = $signed({2'b00, selAnchor & ~selMask});
    winHi     = winLo + $signed({2'b00, selLen});
    if (selLen == '0)        fixSum = stepSum;
    else if (stepSum < winLo) fixSum = stepSum + $signed({2'b00, selLen});
    else if (stepSum >= winHi) fixSum = stepSum - $signed({2'b00, selLen});
    else                     fixSum = stepSum;
    stepNext = fixSum[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REG; i++) begin
        idxReg[i]    <= '0;
        modReg[i]    <= '0;
        lenReg[i]    <= '0;
        anchorReg[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REG; i++) begin
        if (strb.idxLoad[i]) begin
          idxReg[i]    <= wrData;
          anchorReg[i] <= wrData;
        end else if (strb.ptrStep[i]) begin
          idxReg[i] <= stepNext;
        end
        if (strb.modLoad[i]) modReg[i] <= wrData;
        if (strb.lenLoad[i]) lenReg[i] <= wrData;
      end
    end
  end

  logic [ADDR_W-1:0] revPtr;
  for (genvar gb = 0; gb < ADDR_W; gb++) begin : g_rev
    assign revPtr[gb] = selPtr[ADDR_W-1-gb];
  end
  assign addrOut = bitRevEn ? revPtr : selPtr;

  always_comb begin
    case (rdKind)
      KIND_INDEX:  rdData = idxReg[rdSel];
      KIND_MODIFY: rdData = modReg[rdSel];
      KIND_LENGTH: rdData = lenReg[rdSel];
      default:     rdData = '0;
    endcase
  end

  // ---------------- checks ----------------
  logic [NUM_REG-1:0] inWin;
  always_comb begin
    for (int i = 0; i < NUM_REG; i++) begin
      logic [EXT_W-1:0] lo;
      lo = {2'b00, anchorReg[i] & ~spanMask(lenReg[i])};
      inWin[i] = ({2'b00, idxReg[i]} >= lo) && ({2'b00, idxReg[i]} < lo + {2'b00, lenReg[i]});
    end
  end

  logic [ADDR_W-1:0] modMag;
  assign modMag = selMod[ADDR_W-1] ? (~selMod + 1'b1) : selMod;

  // R6
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|strb.ptrStep) && selLen != '0) |-> (modMag <= selLen && inWin[strb.ptrPick]));

  for (genvar gp = 0; gp < NUM_REG; gp++) begin : g_chk
    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ptrStep[gp] && lenReg[gp] == '0) |=>
        idxReg[gp] == $past(idxReg[gp] + modReg[strb.modPick]));
    // R6
    circ_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ptrStep[gp] && lenReg[gp] != '0 && inWin[gp] && !strb.lenLoad[gp]) |=> inWin[gp]);
    // R7
    idle_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.ptrStep[gp] && !strb.idxLoad[gp]) |=> $stable(idxReg[gp]));
    // R7
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.modLoad[gp] |=> $stable(modReg[gp]));
    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.idxLoad[gp] |=> idxReg[gp] == $past(wrData));
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import circ_dag_pkg::*;
#(
  parameter int ADDR_W  = DagAddrW,
  parameter int NUM_REG = DagNumReg,
  localparam int SEL_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdKind,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [ADDR_W-1:0] rdData,
  input  logic              accEn,
  input  logic [SEL_W-1:0]  accPtrSel,
  input  logic [SEL_W-1:0]  accModSel,
  input  logic              bitRevEn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid
);
  dagStrobe_t strb;

  dag_ctrl #(.NUM_REG(NUM_REG), .SEL_W(SEL_W)) u_ctrl (
    .wrEn(wrEn), .wrKind(wrKind), .wrSel(wrSel), .accEn(accEn),
    .accPtrSel(accPtrSel), .accModSel(accModSel), .strb(strb)
  );

  dag_datapath #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdKind(rdKind),
    .rdSel(rdSel), .bitRevEn(bitRevEn), .rdData(rdData), .addrOut(addrOut)
  );

  assign addrValid = accEn;
endmodule

// File: tb/circ_addr_gen_tb.sv
module circ_addr_gen_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, wrEn, accEn, bitRevEn, addrValid;
  logic [1:0]  wrKind, wrSel, rdKind, rdSel, accPtrSel, accModSel;
  logic [13:0] wrData, rdData, addrOut;

  circ_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrSel(wrSel),
    .wrData(wrData), .rdKind(rdKind), .rdSel(rdSel), .rdData(rdData),
    .accEn(accEn), .accPtrSel(accPtrSel), .accModSel(accModSel),
    .bitRevEn(bitRevEn), .addrOut(addrOut), .addrValid(addrValid)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int mReg [3][4];
  int mAnchor [4];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int rev14(int v);
    int r = 0;
    for (int b = 0; b < 14; b++) if (v[b]) r |= (1 << (13 - b));
    return r;
  endfunction

  function automatic int modelNext(int p, int m);
    int step, s, len, pw, base;
    step = (mReg[1][m] >= 'h2000) ? mReg[1][m] - 'h4000 : mReg[1][m];
    s = mReg[0][p] + step;
    len = mReg[2][p];
    if (len == 0) return s & 'h3FFF;
    pw = 1;
    while (pw < len) pw = pw * 2;
    base = mAnchor[p] - (mAnchor[p] % pw);
    if (s < base) s = s + len;
    else if (s >= base + len) s = s - len;
    return s;
  endfunction

  task automatic writeReg(int kind, int sel, int data);
    @(negedge clk);
    wrEn = 1'b1; wrKind = kind[1:0]; wrSel = sel[1:0]; wrData = data[13:0];
    @(posedge clk); #1;
    wrEn = 1'b0;
    if (kind < 3) begin
      mReg[kind][sel] = data & 'h3FFF;
      if (kind == 0) mAnchor[sel] = data & 'h3FFF;
    end
  endtask

  task automatic access(string tag, int p, int m, bit rev);
    int nxt;
    @(negedge clk);
    accEn = 1'b1; accPtrSel = p[1:0]; accModSel = m[1:0]; bitRevEn = rev;
    #1;
    check(tag, addrOut, rev ? rev14(mReg[0][p]) : mReg[0][p]);
    check({tag, " R4 valid"}, addrValid, 1);
    nxt = modelNext(p, m);
    @(posedge clk); #1;
    accEn = 1'b0; bitRevEn = 1'b0;
    mReg[0][p] = nxt;
  endtask

  task automatic readAll(string tag);
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 4; s++) begin
        rdKind = k[1:0]; rdSel = s[1:0];
        #1;
        check(tag, rdData, mReg[k][s]);
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lens [6] = '{1, 3, 5, 8, 10, 13};
    rstN = 1'b0; wrEn = 1'b0; accEn = 1'b0; bitRevEn = 1'b0;
    wrKind = 2'b00; wrSel = 2'b00; wrData = '0; rdKind = 2'b00; rdSel = 2'b00;
    accPtrSel = 2'b00; accModSel = 2'b00;
    for (int k = 0; k < 3; k++) for (int s = 0; s < 4; s++) mReg[k][s] = 0;
    for (int s = 0; s < 4; s++) mAnchor[s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    readAll("R1 reset");
    check("R1 valid idle", addrValid, 0);

    // R2 write and read every register
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 4; s++) writeReg(k, s, ('h0531 * (k * 4 + s + 1)) & 'h3FFF);
    readAll("R2 readback");
    for (int s = 0; s < 4; s++) writeReg(2, s, 0);

    // R3 kind 11 ignored
    writeReg(3, 1, 'h2AAA);
    readAll("R3 ignored kind");

    // R4 R5 linear sweep, including wrap through 0x3FFF
    writeReg(1, 0, 1); writeReg(1, 1, 'h3FFF); writeReg(1, 2, 'h0100); writeReg(1, 3, 'h3E00);
    writeReg(0, 0, 'h3FFE); writeReg(0, 1, 'h0001); writeReg(0, 2, 'h3F80); writeReg(0, 3, 'h0150);
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++)
        repeat (3) access("R5 linear", p, m, 1'b0);
    readAll("R7 regs after linear");

    // R6 circular windows
    foreach (lens[i]) begin
      int L = lens[i];
      int p = i % 4;
      writeReg(2, p, L);
      writeReg(0, p, 'h140 + (L - 1) / 2);
      writeReg(1, 0, 1);
      writeReg(1, 1, 'h3FFF);
      writeReg(1, 2, (L < 3) ? L : 3);
      writeReg(1, 3, ('h4000 - ((L < 2) ? L : 2)) & 'h3FFF);
      for (int m = 0; m < 4; m++)
        repeat (L + 3) access("R6 circular", p, m, 1'b0);
      readAll("R7 regs after circular");
      writeReg(2, p, 0);
    end

    // R8 same-pointer write beats step
    writeReg(0, 2, 'h0200);
    writeReg(1, 0, 1);
    @(negedge clk);
    wrEn = 1'b1; wrKind = 2'b00; wrSel = 2'd2; wrData = 'h1234;
    accEn = 1'b1; accPtrSel = 2'd2; accModSel = 2'd0;
    #1;
    check("R8 old address shown", addrOut, 'h0200);
    @(posedge clk); #1;
    wrEn = 1'b0; accEn = 1'b0;
    mReg[0][2] = 'h1234; mAnchor[2] = 'h1234;
    readAll("R8 write wins");
    access("R8 next access", 2, 0, 1'b0);

    // R8 different pointers: both take effect
    @(negedge clk);
    wrEn = 1'b1; wrKind = 2'b00; wrSel = 2'd3; wrData = 'h0777;
    accEn = 1'b1; accPtrSel = 2'd2; accModSel = 2'd0;
    @(posedge clk); #1;
    wrEn = 1'b0; accEn = 1'b0;
    mReg[0][2] = modelNext(2, 0);
    mReg[0][3] = 'h0777; mAnchor[3] = 'h0777;
    readAll("R8 independent write and step");

    // R9 mirrored output
    for (int b = 0; b < 14; b++) begin
      writeReg(0, 1, 1 << b);
      access("R9 bitrev one-hot", 1, 1, 1'b1);
    end
    writeReg(0, 1, 'h1234);
    access("R9 bitrev pattern", 1, 0, 1'b1);
    access("R9 bitrev pattern", 1, 1, 1'b1);
    writeReg(0, 0, 'h2F0F);
    access("R9 bitrev pattern", 0, 2, 1'b1);
    readAll("R9 update unaffected");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule